// File: doc/BRIEF.md
# Debug-Mode Entry Controller

This block sits beside a processor core and decides when the core stops for background debugging. It watches three stop events: a hardware breakpoint request, a double bus fault (which carries a 16-bit fault status word), and a strobe from the decoder saying a background instruction was executed. When any of them arrives while the core is running, the block raises `freeze` and suspends the core. One cycle later it opens the host command path (`cmd_en`). At the moment of entry it records a 32-bit stop-cause word in a temporary register. This word tells the host which event caused the stop.

The block also keeps the debug context. The fault address register tracks the address of the most recent faulting bus cycle. The resume address register holds the address where fetching restarts. The current-instruction register points at the first word of the last instruction that completed. The host reads any of the four registers through a 2-bit select. While the command path is open, the host may overwrite the temporary register and the resume address. A `host_go` strobe ends debug mode. On the way out, the block flags an address error if the resume address is odd.

Four states describe the controller. RUN is normal execution. ENTER is the single cycle in which `freeze` is up but commands are not yet accepted. FROZEN is where the command path is open. RESUME is a one-cycle exit that pulses `restart`. The transitions are:
- RUN→ENTER on any stop event.
- ENTER→FROZEN unconditionally.
- FROZEN→RESUME on `host_go`.
- RESUME→RUN unconditionally.

Top module: `dbg_entry_ctl`

## Requirements
- R1: While the core is running (RUN, `freeze` and `restart` both low), a cycle with `brk_req`, `dbf_req` or `bgnd_strobe` high makes `freeze` read 1 after the next clock edge.
- R2: `cmd_en` goes high exactly one cycle after `freeze` rises. It is high only in FROZEN, and `freeze` is always high whenever `cmd_en` is high.
- R3: Entry by double bus fault loads the temporary register with `dbf_ssw` in bits 31:16 and 0xFFFF in bits 15:0.
- R4: Entry by background instruction loads 0x00000001. Entry by breakpoint loads 0x00000000.
- R5: When several stop events coincide, the double bus fault wins, then the breakpoint, then the background instruction.
- R6: Any bus cycle with `bus_valid` and `bus_err` both high loads the fault address register with `bus_addr`. A cycle without `bus_err` leaves it unchanged, so the later of two faults is the one kept.
- R7: In RUN, `insn_done` loads the current-instruction register with `insn_addr` with bit 0 cleared. The register is held throughout debug mode. A double bus fault entry with `dbf_init` high sets it to 0xFFFFFFFF, the only case in which it can be odd.
- R8: On entry, the resume address register is loaded with `fetch_addr`.
- R9: `host_sel` selects the register: 0 is the temporary register, 1 the fault address, 2 the resume address, 3 the current instruction. `host_rdata` shows the selected register in the same cycle. `host_wr` takes effect only while `cmd_en` is high and only for selects 0 and 2; all other writes are ignored.
- R10: `host_go` in FROZEN leads to one cycle with `restart` high, `freeze` low, `resume_pc` equal to the resume address register, and `addr_err` equal to its bit 0. After that cycle the controller is back in RUN.
- R11: Stop events that arrive while the controller is in ENTER, FROZEN or RESUME are ignored, and the stored cause is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_req | input | 1 | Hardware breakpoint request |
| dbf_req | input | 1 | Double bus fault indication |
| dbf_ssw | input | 16 | Fault status word carried with a double bus fault |
| dbf_init | input | 1 | The double fault happened during the initial stack/PC fetch |
| bgnd_strobe | input | 1 | Background instruction decoded |
| bus_valid | input | 1 | A bus cycle completes this clock |
| bus_err | input | 1 | The completing bus cycle faulted (bus or address error) |
| bus_addr | input | 32 | Address of the completing bus cycle |
| insn_done | input | 1 | An instruction completed this clock |
| insn_addr | input | 32 | Address of the first word of the completing instruction |
| fetch_addr | input | 32 | Next fetch address |
| host_sel | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_go | input | 1 | Host request to leave debug mode |
| host_rdata | output | 32 | Selected register value |
| freeze | output | 1 | Core suspended in debug mode |
| cmd_en | output | 1 | Host command path open |
| restart | output | 1 | One-cycle pulse: normal fetching restarts |
| resume_pc | output | 32 | Address where fetching restarts |
| addr_err | output | 1 | Resume address is odd at restart |

## Verification
The assertions check the following on every cycle:
- Each stop event seen in RUN raises `freeze` on the next edge.
- `cmd_en` never rises without `freeze` already being up.
- The cause word matches the event priority and status word.
- The current-instruction register is odd only as all ones, and it does not move while frozen.
- The stored cause is not disturbed by anything other than a host write.
- The restart pulse carries the resume address and its odd-bit flag.

Only the bench's scenarios can show the following:
- The fault address register keeping the latest of two faults and ignoring clean cycles.
- Bit 0 being stripped from completed-instruction addresses.
- Host writes to read-only selects, or outside FROZEN, leaving the registers untouched.
- A host-written odd resume address producing the error flag.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ENTER  = 2'd1,
        ST_FROZEN = 2'd2,
        ST_RESUME = 2'd3
    } dbg_state_t;

    typedef enum logic [1:0] {
        REG_TEMP = 2'd0,
        REG_FAR  = 2'd1,
        REG_RPC  = 2'd2,
        REG_PCC  = 2'd3
    } host_reg_t;

endpackage

// File: rtl/dbg_cause_enc.sv
// Prioritised stop-cause encoder: double fault > breakpoint > background insn.
module dbg_cause_enc #(
    parameter int SW = 16
) (
    input  logic            brk,
    input  logic            dbf,
    input  logic            bgnd,
    input  logic [SW-1:0]   ssw,
    output logic            hit,
    output logic            is_dbf,
    output logic [2*SW-1:0] cause
);
    localparam int TW = 2 * SW;

    always_comb begin
        hit    = brk | dbf | bgnd;
        is_dbf = dbf;
        if (dbf) begin
            cause = {ssw, {SW{1'b1}}};
        end else if (brk) begin
            cause = '0;
        end else if (bgnd) begin
            cause = {{(TW-1){1'b0}}, 1'b1};
        end else begin
            cause = '0;
        end
    end
endmodule

// File: rtl/dbg_ctx_regs.sv
// Debug context storage: cause word, fault address, resume PC, current-insn PC.
module dbg_ctx_regs #(
    parameter int AW = 32,
    parameter int TW = 32,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap,
    input  logic [TW-1:0]        cause,
    input  logic                 pcc_poison,
    input  logic [AW-1:0]        fetch_addr,
    input  logic                 track,
    input  logic                 insn_done,
    input  logic [AW-1:0]        insn_addr,
    input  logic                 bus_valid,
    input  logic                 bus_err,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 wr_en,
    input  dbg_pkg::host_reg_t   wr_sel,
    input  logic [DW-1:0]        wr_data,
    output logic [TW-1:0]        temp_q,
    output logic [AW-1:0]        far_q,
    output logic [AW-1:0]        rpc_q,
    output logic [AW-1:0]        pcc_q
);
    import dbg_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
            far_q  <= '0;
            rpc_q  <= '0;
            pcc_q  <= '0;
        end else begin
            if (bus_valid && bus_err) begin
                far_q <= bus_addr;
            end
            if (cap) begin
                temp_q <= cause;
                rpc_q  <= fetch_addr;
                if (pcc_poison) begin
                    pcc_q <= '1;
                end
            end else if (track && insn_done) begin
                pcc_q <= {insn_addr[AW-1:1], 1'b0};
            end
            if (wr_en) begin
                case (wr_sel)
                    REG_TEMP: temp_q <= wr_data[TW-1:0];
                    REG_RPC:  rpc_q  <= wr_data[AW-1:0];
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dbg_entry_ctl.sv
// Debug-mode entry controller: four-state sequencer plus context registers.
module dbg_entry_ctl #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          brk_req,
    input  logic          dbf_req,
    input  logic [SW-1:0] dbf_ssw,
    input  logic          dbf_init,
    input  logic          bgnd_strobe,
    input  logic          bus_valid,
    input  logic          bus_err,
    input  logic [AW-1:0] bus_addr,
    input  logic          insn_done,
    input  logic [AW-1:0] insn_addr,
    input  logic [AW-1:0] fetch_addr,
    input  logic [1:0]    host_sel,
    input  logic          host_wr,
    input  logic [((AW > 2*SW) ? AW : 2*SW)-1:0] host_wdata,
    input  logic          host_go,
    output logic [((AW > 2*SW) ? AW : 2*SW)-1:0] host_rdata,
    output logic          freeze,
    output logic          cmd_en,
    output logic          restart,
    output logic [AW-1:0] resume_pc,
    output logic          addr_err
);
    import dbg_pkg::*;

    localparam int TW = 2 * SW;
    localparam int DW = (AW > TW) ? AW : TW;

    dbg_state_t state_q, state_d;
    host_reg_t  sel;

    logic          ev_hit, ev_dbf;
    logic [TW-1:0] ev_cause;
    logic [TW-1:0] temp_q;
    logic [AW-1:0] far_q, rpc_q, pcc_q;
    logic          in_run, cap, wr_en;

    assign sel    = host_reg_t'(host_sel);
    assign in_run = (state_q == ST_RUN);
    assign cap    = in_run && ev_hit;
    assign wr_en  = host_wr && (state_q == ST_FROZEN);

    dbg_cause_enc #(.SW(SW)) u_enc (
        .brk    (brk_req),
        .dbf    (dbf_req),
        .bgnd   (bgnd_strobe),
        .ssw    (dbf_ssw),
        .hit    (ev_hit),
        .is_dbf (ev_dbf),
        .cause  (ev_cause)
    );

    dbg_ctx_regs #(.AW(AW), .TW(TW), .DW(DW)) u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (cap),
        .cause      (ev_cause),
        .pcc_poison (ev_dbf && dbf_init),
        .fetch_addr (fetch_addr),
        .track      (in_run),
        .insn_done  (insn_done),
        .insn_addr  (insn_addr),
        .bus_valid  (bus_valid),
        .bus_err    (bus_err),
        .bus_addr   (bus_addr),
        .wr_en      (wr_en),
        .wr_sel     (sel),
        .wr_data    (host_wdata),
        .temp_q     (temp_q),
        .far_q      (far_q),
        .rpc_q      (rpc_q),
        .pcc_q      (pcc_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (ev_hit)  state_d = ST_ENTER;
            ST_ENTER:               state_d = ST_FROZEN;
            ST_FROZEN: if (host_go) state_d = ST_RESUME;
            ST_RESUME:              state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        freeze    = 1'b0;
        cmd_en    = 1'b0;
        restart   = 1'b0;
        addr_err  = 1'b0;
        resume_pc = rpc_q;
        unique case (state_q)
            ST_RUN:    ;
            ST_ENTER:  freeze = 1'b1;
            ST_FROZEN: begin
                freeze = 1'b1;
                cmd_en = 1'b1;
            end
            ST_RESUME: begin
                restart  = 1'b1;
                addr_err = rpc_q[0];
            end
        endcase
    end

    // Host read mux
    always_comb begin
        unique case (sel)
            REG_TEMP: host_rdata = DW'(temp_q);
            REG_FAR:  host_rdata = DW'(far_q);
            REG_RPC:  host_rdata = DW'(rpc_q);
            REG_PCC:  host_rdata = DW'(pcc_q);
        endcase
    end
endmodule

// File: rtl/dbg_entry_chk.sv
// Property checker for the debug-mode entry controller.
module dbg_entry_chk #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            brk_req,
    input logic            dbf_req,
    input logic [SW-1:0]   dbf_ssw,
    input logic            bgnd_strobe,
    input logic            host_wr,
    input logic            freeze,
    input logic            cmd_en,
    input logic            restart,
    input logic            addr_err,
    input logic [AW-1:0]   resume_pc,
    input logic [2*SW-1:0] temp_q,
    input logic [AW-1:0]   rpc_q,
    input logic [AW-1:0]   pcc_q
);
    localparam int TW = 2 * SW;

    logic running;
    assign running = !freeze && !restart;

    a_r1_enter_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (brk_req || dbf_req || bgnd_strobe)) |=> freeze);

    a_r2_cmd_needs_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |-> freeze);

    a_r2_cmd_after_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_en) |-> $past(freeze));

    a_r3_dbf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dbf_req) |=> (temp_q == {$past(dbf_ssw), {SW{1'b1}}}));

    a_r5_brk_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !dbf_req && brk_req) |=> (temp_q == '0));

    a_r4_bgnd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !dbf_req && !brk_req && bgnd_strobe)
        |=> (temp_q == {{(TW-1){1'b0}}, 1'b1}));

    a_r7_pcc_even: assert property (@(posedge clk) disable iff (!rst_n)
        pcc_q[0] |-> (&pcc_q));

    a_r7_pcc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> (!freeze || $stable(pcc_q)));

    a_r11_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !(cmd_en && host_wr)) |=> $stable(temp_q));

    a_r10_restart_flag: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (!freeze && (addr_err == rpc_q[0]) && (resume_pc == rpc_q)));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);
endmodule

bind dbg_entry_ctl dbg_entry_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .brk_req     (brk_req),
    .dbf_req     (dbf_req),
    .dbf_ssw     (dbf_ssw),
    .bgnd_strobe (bgnd_strobe),
    .host_wr     (host_wr),
    .freeze      (freeze),
    .cmd_en      (cmd_en),
    .restart     (restart),
    .addr_err    (addr_err),
    .resume_pc   (resume_pc),
    .temp_q      (temp_q),
    .rpc_q       (rpc_q),
    .pcc_q       (pcc_q)
);

// File: tb/dbg_entry_ctl_tb.sv
`timescale 1ns/1ps
module dbg_entry_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        brk_req = 0, dbf_req = 0, dbf_init = 0, bgnd_strobe = 0;
    logic [15:0] dbf_ssw = '0;
    logic        bus_valid = 0, bus_err = 0;
    logic [31:0] bus_addr = '0, insn_addr = '0, fetch_addr = '0;
    logic        insn_done = 0;
    logic [1:0]  host_sel = '0;
    logic        host_wr = 0, host_go = 0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata, resume_pc;
    logic        freeze, cmd_en, restart, addr_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model: 0 run, 1 enter, 2 frozen, 3 resume
    int          m_st = 0;
    logic [31:0] m_temp = '0, m_far = '0, m_rpc = '0, m_pcc = '0;

    always #10 clk = ~clk;

    dbg_entry_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .dbf_req(dbf_req),
        .dbf_ssw(dbf_ssw), .dbf_init(dbf_init), .bgnd_strobe(bgnd_strobe),
        .bus_valid(bus_valid), .bus_err(bus_err), .bus_addr(bus_addr),
        .insn_done(insn_done), .insn_addr(insn_addr), .fetch_addr(fetch_addr),
        .host_sel(host_sel), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_go(host_go), .host_rdata(host_rdata), .freeze(freeze),
        .cmd_en(cmd_en), .restart(restart), .resume_pc(resume_pc),
        .addr_err(addr_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cause_of(logic d, logic b, logic [15:0] s);
        if (d) return {s, 16'hFFFF};
        if (b) return 32'h0;
        return 32'h1;
    endfunction

    task automatic clear_inputs();
        brk_req = 0; dbf_req = 0; dbf_init = 0; bgnd_strobe = 0;
        bus_valid = 0; bus_err = 0; insn_done = 0;
        host_wr = 0; host_go = 0;
    endtask

    // model update from the inputs now applied, then one clock
    task automatic step();
        logic ev;
        ev = brk_req | dbf_req | bgnd_strobe;
        if (bus_valid && bus_err) m_far = bus_addr;
        case (m_st)
            0: if (ev) begin
                   m_temp = cause_of(dbf_req, brk_req, dbf_ssw);
                   m_rpc  = fetch_addr;
                   if (dbf_req && dbf_init) m_pcc = 32'hFFFF_FFFF;
                   m_st = 1;
               end else if (insn_done) begin
                   m_pcc = {insn_addr[31:1], 1'b0};
               end
            1: m_st = 2;
            2: begin
                   if (host_wr && host_sel == 2'd0) m_temp = host_wdata;
                   if (host_wr && host_sel == 2'd2) m_rpc  = host_wdata;
                   if (host_go) m_st = 3;
               end
            default: m_st = 0;
        endcase
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic rd(input logic [1:0] s, input logic [31:0] exp, input string tag);
        host_sel = s;
        #1;
        chk(tag, host_rdata, exp);
    endtask

    task automatic check_all();
        chk("R1 freeze", {31'd0, freeze}, {31'd0, (m_st == 1 || m_st == 2)});
        chk("R2 cmd_en", {31'd0, cmd_en}, {31'd0, (m_st == 2)});
        chk("R10 restart", {31'd0, restart}, {31'd0, (m_st == 3)});
        chk("R10 addr_err", {31'd0, addr_err}, {31'd0, (m_st == 3) && m_rpc[0]});
        if (m_st == 3) chk("R10 resume_pc", resume_pc, m_rpc);
        rd(2'd0, m_temp, "R9 read temp (R3/R4)");
        rd(2'd1, m_far,  "R9 read far (R6)");
        rd(2'd2, m_rpc,  "R9 read rpc (R8)");
        rd(2'd3, m_pcc,  "R9 read pcc (R7)");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check_all();

        // R6: fault capture, clean cycle ignored, later fault wins
        bus_valid = 1; bus_err = 1; bus_addr = 32'h0000_4000; step(); check_all();
        bus_valid = 1; bus_addr = 32'h0000_5000; step(); check_all();
        rd(2'd1, 32'h0000_4000, "R6 clean cycle keeps fault address");
        bus_valid = 1; bus_err = 1; bus_addr = 32'h0000_6002; step(); check_all();
        rd(2'd1, 32'h0000_6002, "R6 later fault overwrites");

        // R7: odd instruction address stripped
        insn_done = 1; insn_addr = 32'h0000_1001; step(); check_all();
        rd(2'd3, 32'h0000_1000, "R7 pcc bit0 cleared");

        // R9: write outside FROZEN ignored
        host_wr = 1; host_sel = 2'd0; host_wdata = 32'hDEAD_BEEF; step(); check_all();

        // R1/R4/R8: background instruction entry
        bgnd_strobe = 1; fetch_addr = 32'h0000_2224; step();
        chk("R1 freeze after bgnd", {31'd0, freeze}, 32'd1);
        chk("R2 cmd_en not yet", {31'd0, cmd_en}, 32'd0);
        check_all();
        step();
        chk("R2 cmd_en one cycle later", {31'd0, cmd_en}, 32'd1);
        rd(2'd0, 32'h0000_0001, "R4 bgnd cause");
        rd(2'd2, 32'h0000_2224, "R8 rpc from fetch_addr");

        // R11: event while frozen ignored
        dbf_req = 1; dbf_ssw = 16'hABCD; insn_done = 1; insn_addr = 32'h10; step(); check_all();
        rd(2'd0, 32'h0000_0001, "R11 cause kept while frozen");
        rd(2'd3, 32'h0000_1000, "R7 pcc held while frozen");

        // R9: write to read-only select ignored; R10: odd resume address
        host_wr = 1; host_sel = 2'd1; host_wdata = 32'h1111_1111; step(); check_all();
        host_wr = 1; host_sel = 2'd2; host_wdata = 32'h0000_2003; step(); check_all();
        host_go = 1; step();
        chk("R10 restart pulse", {31'd0, restart}, 32'd1);
        chk("R10 odd resume flagged", {31'd0, addr_err}, 32'd1);
        chk("R10 resume_pc", resume_pc, 32'h0000_2003);
        check_all();
        step(); check_all();

        // R5/R3/R7: all events together, double fault during initial fetch
        dbf_req = 1; brk_req = 1; bgnd_strobe = 1; dbf_init = 1; dbf_ssw = 16'h1234;
        fetch_addr = 32'h0000_0100; step(); check_all();
        rd(2'd0, 32'h1234_FFFF, "R5 R3 double fault wins");
        rd(2'd3, 32'hFFFF_FFFF, "R7 pcc all ones on initial double fault");
        step(); host_go = 1; step(); check_all();
        step(); check_all();

        // R5/R4: breakpoint over background instruction
        brk_req = 1; bgnd_strobe = 1; step(); check_all();
        rd(2'd0, 32'h0000_0000, "R5 R4 breakpoint cause");
        step(); host_go = 1; step();
        chk("R10 even resume no error", {31'd0, addr_err}, 32'd0);
        step(); check_all();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            bus_valid  = ($urandom % 3) == 0;
            bus_err    = ($urandom % 2) == 0;
            bus_addr   = $urandom;
            insn_done  = ($urandom % 2) == 0;
            insn_addr  = $urandom;
            fetch_addr = $urandom;
            dbf_ssw    = 16'($urandom);
            if (($urandom % 8) == 0) begin
                brk_req     = ($urandom % 2) == 0;
                dbf_req     = ($urandom % 3) == 0;
                bgnd_strobe = ($urandom % 2) == 0;
                dbf_init    = ($urandom % 2) == 0;
            end
            host_wr    = ($urandom % 3) == 0;
            host_sel   = 2'($urandom);
            host_wdata = $urandom;
            host_go    = ($urandom % 6) == 0;
            step();
            check_all();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule